// File: doc/BRIEF.md
# Expansion Card Bank-Select Controller

This controller sits on a ROM expansion card attached to an 8-bit parallel expansion bus. It watches the host address bus and write strobes, decodes a 2 KiB ROM window at $D800-$DFFF, and keeps two small control registers. These are a card-select register at $D1FF and a control register at $D100. From these it drives the flash chip enable, the card data-buffer enable, and the lines that tell the host to turn off its own memory in a region.

A boot routine on the host first selects the card by setting its device bit at $D1FF. It then writes the control register to pick one of two 64 KiB flash banks and to engage the window remap. Last, it writes $00 to $D1FF to deselect the card. Both control bits are active-low. Because the remap bit survives deselection, the card keeps answering in the floating-point ROM region from then on. The host math routines are replaced this way until the next system reset.

Top module: `xcard_bank_ctrl`

## Requirements
- R1: After reset the card is deselected, the remap is off and `flash_bank` is 0. A read in $D800-$DFFF leaves every active-low output high.
- R2: A write to $D1FF that has data bit `dev_id` set selects the card. While the card is selected, a read in $D800-$DFFF drives `flash_ce_n`, `buf_en_n`, `mpd_n`, `extsel_n` and `ram_dis_n` low.
- R3: A write to $D1FF that has data bit `dev_id` clear (for example $00) deselects the card. Without remap, window accesses are then ignored.
- R4: A write to $D100 while the card is selected loads data bit 1, active-low, as the bank choice: 0 gives `flash_bank`=1 (upper bank) and 1 gives `flash_bank`=0.
- R5: Data bit 0 of that same write, active-low, is the remap latch. Once engaged, window accesses still assert `mpd_n`, `extsel_n` and `ram_dis_n`, and reads still assert `flash_ce_n`, after the card is deselected.
- R6: Writes to $D100 while the card is deselected change neither latch.
- R7: The latches change only on a write (`rd_wr`=0) with `bus_en`=1. A write with `bus_en`=0, or any read, has no effect.
- R8: A read of $D100 never enables the data buffer. A qualified write to $D1FF, or to $D100 while selected, does enable it.
- R9: While the card is selected, `ram_dis_n` is low for any address whose A15-A13 region is set in `RAM_OFF_MASK` (by default region 5, $A000-$BFFF). It is also low for every window access the card owns.
- R10: Outside $D800-$DFFF, `flash_ce_n`, `mpd_n` and `extsel_n` stay high whatever the latch state.
- R11: A synchronous reset pulse returns the remap to off, the bank to 0 and the card to deselected.
- R12: Only data bit `dev_id` of a $D1FF write counts. A value with every other bit set does not select the card.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_en | input | 1 | Qualified bus cycle strobe; writes take effect only when high |
| addr | input | 16 | Host address bus |
| din | input | 8 | Host data bus as seen by the card |
| rd_wr | input | 1 | 1 = read cycle, 0 = write cycle |
| dev_id | input | 3 | Header-strapped device number; picks the $D1FF bit |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_bank | output | 1 | Flash bank address line (1 = upper 64 KiB bank) |
| buf_en_n | output | 1 | Card data-buffer enable, active low |
| mpd_n | output | 1 | Host floating-point ROM disable, active low |
| extsel_n | output | 1 | Host internal memory disable, active low |
| ram_dis_n | output | 1 | Expansion RAM disable, active low |

## Verification
The hardest state to reach is an engaged remap with the card deselected. Getting there takes a select write, a control write with bit 0 clear, and then a deselect write whose data has every bit except `dev_id` set. That last write also checks that only the strapped bit is decoded. The vector table walks through this order. It then shows that window reads still enable the flash, while writes to $D100 without selection and control writes with `bus_en` low leave the bank line unchanged. Directed tests follow: a reset pulse from the remapped state, and selection by a value with all bits set.

// File: rtl/xcard_pkg.sv
package xcard_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int ID_W      = $clog2(DATA_W);
    localparam int WIN_LOG2  = 11;
    localparam int REGION_W  = 3;
    localparam int REGIONS   = 1 << REGION_W;
    localparam int CTL_N     = 2;

    localparam logic [ADDR_W-1:0] WIN_BASE = 16'hD800;
    localparam logic [ADDR_W-1:0] CTL_ADDR = 16'hD100;
    localparam logic [ADDR_W-1:0] SEL_ADDR = 16'hD1FF;

    // bit positions inside the active-low control register
    localparam int CTL_REMAP_BIT = 0;
    localparam int CTL_BANK_BIT  = 1;

    typedef struct packed {
        logic                win;
        logic                ctl;
        logic                sel;
        logic [REGION_W-1:0] region;
    } dec_t;

    typedef struct packed {
        logic selected;
        logic remap;
        logic bank_hi;
    } latch_t;

    function automatic logic same_page(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base);
        return a[ADDR_W-1:WIN_LOG2] == base[ADDR_W-1:WIN_LOG2];
    endfunction

endpackage

// File: rtl/xcard_addr_dec.sv
module xcard_addr_dec
    import xcard_pkg::*;
#(
    parameter logic [ADDR_W-1:0] P_WIN_BASE = WIN_BASE,
    parameter logic [ADDR_W-1:0] P_CTL_ADDR = CTL_ADDR,
    parameter logic [ADDR_W-1:0] P_SEL_ADDR = SEL_ADDR
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec.win    = same_page(addr, P_WIN_BASE);
        dec.ctl    = (addr == P_CTL_ADDR);
        dec.sel    = (addr == P_SEL_ADDR);
        dec.region = addr[ADDR_W-1 -: REGION_W];
    end

endmodule

// File: rtl/xcard_ctl_latches.sv
module xcard_ctl_latches
    import xcard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              rd_wr,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] din,
    input  logic [ID_W-1:0]   dev_id,
    output latch_t            st
);

    logic             wr_q;
    logic             sel_q;
    logic [CTL_N-1:0] ctl_n_q;   // active-low control latches

    assign wr_q = bus_en && !rd_wr;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= 1'b0;
        else if (wr_q && dec.sel)
            sel_q <= din[dev_id];
    end

    for (genvar i = 0; i < CTL_N; i++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (rst)
                ctl_n_q[i] <= 1'b1;
            else if (wr_q && dec.ctl && sel_q)
                ctl_n_q[i] <= din[i];
        end
    end

    always_comb begin
        st.selected = sel_q;
        st.remap    = !ctl_n_q[CTL_REMAP_BIT];
        st.bank_hi  = !ctl_n_q[CTL_BANK_BIT];
    end

endmodule

// File: rtl/xcard_out_drv.sv
module xcard_out_drv
    import xcard_pkg::*;
#(
    parameter logic [REGIONS-1:0] RAM_OFF_MASK = 8'b0010_0000
) (
    input  dec_t   dec,
    input  latch_t st,
    input  logic   bus_en,
    input  logic   rd_wr,
    output logic   flash_ce_n,
    output logic   flash_bank,
    output logic   buf_en_n,
    output logic   mpd_n,
    output logic   extsel_n,
    output logic   ram_dis_n
);

    logic owned;
    logic reg_wr;
    logic region_off;

    always_comb begin
        owned      = dec.win && (st.selected || st.remap);
        reg_wr     = !rd_wr && (dec.sel || (dec.ctl && st.selected));
        region_off = st.selected && RAM_OFF_MASK[dec.region];

        flash_ce_n = !(owned && rd_wr);
        flash_bank = st.bank_hi;
        buf_en_n   = !(bus_en && ((owned && rd_wr) || reg_wr));
        mpd_n      = !owned;
        extsel_n   = !owned;
        ram_dis_n  = !(owned || region_off);
    end

endmodule

// File: rtl/xcard_bank_ctrl.sv
module xcard_bank_ctrl
    import xcard_pkg::*;
#(
    parameter logic [REGIONS-1:0] RAM_OFF_MASK = 8'b0010_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_wr,
    input  logic [ID_W-1:0]   dev_id,
    output logic              flash_ce_n,
    output logic              flash_bank,
    output logic              buf_en_n,
    output logic              mpd_n,
    output logic              extsel_n,
    output logic              ram_dis_n
);

    dec_t   dec;
    latch_t st;

    xcard_addr_dec u_dec (
        .addr (addr),
        .dec  (dec)
    );

    xcard_ctl_latches u_lat (
        .clk    (clk),
        .rst    (rst),
        .bus_en (bus_en),
        .rd_wr  (rd_wr),
        .dec    (dec),
        .din    (din),
        .dev_id (dev_id),
        .st     (st)
    );

    xcard_out_drv #(.RAM_OFF_MASK(RAM_OFF_MASK)) u_out (
        .dec        (dec),
        .st         (st),
        .bus_en     (bus_en),
        .rd_wr      (rd_wr),
        .flash_ce_n (flash_ce_n),
        .flash_bank (flash_bank),
        .buf_en_n   (buf_en_n),
        .mpd_n      (mpd_n),
        .extsel_n   (extsel_n),
        .ram_dis_n  (ram_dis_n)
    );

endmodule

// File: rtl/xcard_bank_ctrl_chk.sv
module xcard_bank_ctrl_chk
    import xcard_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_wr,
    input logic              flash_ce_n,
    input logic              flash_bank,
    input logic              buf_en_n,
    input logic              mpd_n,
    input logic              ram_dis_n
);

    // R10: flash enabled only inside the window
    p_ce_in_window_r10: assert property (@(posedge clk) disable iff (rst)
        !flash_ce_n |-> same_page(addr, WIN_BASE));

    // R2: flash enabled only on read cycles
    p_ce_on_read_r2: assert property (@(posedge clk) disable iff (rst)
        !flash_ce_n |-> rd_wr);

    // R8: control register reads never open the buffer
    p_no_buf_ctl_read_r8: assert property (@(posedge clk) disable iff (rst)
        (addr == CTL_ADDR && rd_wr) |-> buf_en_n);

    // R7: bank only moves after a qualified write to the control register
    p_bank_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && !rd_wr && addr == CTL_ADDR) |=> $stable(flash_bank));

    // R11: bank is low on the first cycle after reset
    p_bank_reset_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !flash_bank);

    // R9: a math-pack takeover always disables expansion RAM too
    p_mpd_ram_r9: assert property (@(posedge clk) disable iff (rst)
        !mpd_n |-> !ram_dis_n);

endmodule

bind xcard_bank_ctrl xcard_bank_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_en     (bus_en),
    .addr       (addr),
    .rd_wr      (rd_wr),
    .flash_ce_n (flash_ce_n),
    .flash_bank (flash_bank),
    .buf_en_n   (buf_en_n),
    .mpd_n      (mpd_n),
    .ram_dis_n  (ram_dis_n)
);

// File: tb/test_xcard_bank_ctrl.sv
`timescale 1ns/1ps
module test_xcard_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  din = 8'h00;
    logic        rd_wr = 1'b1;
    logic [2:0]  dev_id = 3'd2;
    logic        flash_ce_n, flash_bank, buf_en_n, mpd_n, extsel_n, ram_dis_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    xcard_bank_ctrl i_xcard_bank_ctrl (
        .clk(clk), .rst(rst), .bus_en(bus_en), .addr(addr), .din(din),
        .rd_wr(rd_wr), .dev_id(dev_id), .flash_ce_n(flash_ce_n),
        .flash_bank(flash_bank), .buf_en_n(buf_en_n), .mpd_n(mpd_n),
        .extsel_n(extsel_n), .ram_dis_n(ram_dis_n)
    );

    // {req, addr, din, rd_wr, bus_en, expected {ce_n, buf_n, mpd_n, ext_n, ram_n, bank}}
    localparam int NV = 18;
    localparam logic [39:0] VEC [NV] = '{
        {8'd1,  16'hD800, 8'h00, 1'b1, 1'b1, 6'b111110}, // R1 idle after reset
        {8'd2,  16'hD1FF, 8'h04, 1'b0, 1'b1, 6'b101110}, // R2 select write, R8 buffer
        {8'd2,  16'hD900, 8'h00, 1'b1, 1'b1, 6'b000000}, // R2 window read owned
        {8'd9,  16'hA000, 8'h00, 1'b1, 1'b1, 6'b111100}, // R9 region 5 RAM off
        {8'd8,  16'hD100, 8'h00, 1'b1, 1'b1, 6'b111110}, // R8 ctl read no buffer
        {8'd7,  16'hD100, 8'hFD, 1'b0, 1'b0, 6'b111110}, // R7 unqualified write
        {8'd7,  16'hD100, 8'h00, 1'b1, 1'b1, 6'b111110}, // R7 bank unchanged
        {8'd4,  16'hD100, 8'hFD, 1'b0, 1'b1, 6'b101110}, // R4 upper bank write
        {8'd4,  16'hDFFF, 8'h00, 1'b1, 1'b1, 6'b000001}, // R4 upper bank seen
        {8'd5,  16'hD100, 8'hFE, 1'b0, 1'b1, 6'b101111}, // R5 remap on, lower bank
        {8'd12, 16'hD1FF, 8'hFB, 1'b0, 1'b1, 6'b101110}, // R12 R3 deselect by bit
        {8'd5,  16'hD800, 8'h00, 1'b1, 1'b1, 6'b000000}, // R5 remap holds
        {8'd5,  16'hD800, 8'h00, 1'b0, 1'b1, 6'b110000}, // R5 write: no flash ce
        {8'd9,  16'hA000, 8'h00, 1'b1, 1'b1, 6'b111110}, // R9 deselected region
        {8'd6,  16'hD100, 8'h00, 1'b0, 1'b1, 6'b111110}, // R6 ctl write ignored
        {8'd6,  16'hD800, 8'h00, 1'b1, 1'b1, 6'b000000}, // R6 bank still low
        {8'd10, 16'hD7FF, 8'h00, 1'b1, 1'b1, 6'b111110}, // R10 below window
        {8'd10, 16'hE000, 8'h00, 1'b1, 1'b1, 6'b111110}  // R10 above window
    };

    task automatic drive(input logic [15:0] a, input logic [7:0] d,
                         input logic rw, input logic en);
        @(negedge clk);
        addr = a; din = d; rd_wr = rw; bus_en = en;
        #1;
    endtask

    task automatic check(input int req, input logic [5:0] exp);
        logic [5:0] act;
        act = {flash_ce_n, buf_en_n, mpd_n, extsel_n, ram_dis_n, flash_bank};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual=%b expected=%b addr=%h", req, act, exp, addr);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][31:16], VEC[i][15:8], VEC[i][7], VEC[i][6]);
            check(int'(VEC[i][39:32]), VEC[i][5:0]);
        end
        // R11: reset pulse from remapped state clears everything
        drive(16'hD100, 8'h00, 1'b1, 1'b0);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        drive(16'hD800, 8'h00, 1'b1, 1'b1);
        check(11, 6'b111110);
        // R7: select write without bus_en does not select
        drive(16'hD1FF, 8'h04, 1'b0, 1'b0);
        drive(16'hD800, 8'h00, 1'b1, 1'b1);
        check(7, 6'b111110);
        // R12: all-ones value selects
        drive(16'hD1FF, 8'hFF, 1'b0, 1'b1);
        drive(16'hD800, 8'h00, 1'b1, 1'b1);
        check(12, 6'b000000);
        // R3: writing $00 deselects; no remap so window is released
        drive(16'hD1FF, 8'h00, 1'b0, 1'b1);
        drive(16'hD800, 8'h00, 1'b1, 1'b1);
        check(3, 6'b111110);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL R1 actual=hang expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule